// File: doc/BRIEF.md
# Protected Supervisor Control and Fault Register File

This block holds two byte-wide registers of a power supervisor: a control byte, which carries the persistent watchdog-interval and power-up-delay selections, and a fault byte, which records which monitored condition last pulled the system into reset. The block sits behind a serial slave that has already decoded its frames. The slave presents a register address, byte write strobes with a flag marking the first data byte of a transaction, a stop strobe that ends the transaction, and read strobes. Each write byte is answered one cycle later with an acknowledge or a refusal.

Persistent control bits are guarded by a three-step ritual. A set-enable byte comes first, then a set-both-enables byte, and only then a byte carrying the new settings. Every step takes effect at the stop that closes its transaction. The final step starts a busy period that stands for the nonvolatile store. While it lasts, every write is refused. The fault byte needs no ritual. Software writes ones to arm the four fault flags, and each flag falls to zero when its event pulse arrives. A write-protect pin refuses writes to both registers.

Top module: `supv_regfile`

## Requirements
- R1: After reset, the control byte reads 61h (watchdog field 11, power-up field 01, both enables clear), the fault byte reads 00h, busy is low, wd_bits is 11 and pup_bits is 01.
- R2: The control byte reads back as bit7 = power-up high bit, bits6:5 = watchdog field, bits4:3 = 0, bit2 = second enable, bit1 = first enable, bit0 = power-up low bit. A read of any address other than the two registers returns 00h. A read changes no state and does not break an enable sequence. rd_data is valid the cycle after rd_stb and holds until the next read.
- R3: While the first enable is clear, the only control byte that is acknowledged is 02h. The stop after it sets the first enable and does not raise busy.
- R4: With the first enable set, 06h sets both enables at the stop and 00h clears both at the stop. Neither raises busy.
- R5: With both enables set, a byte with bits4:3 = 00, bit2 = 0 and bit1 = 1 is acknowledged. At the stop it loads the watchdog field from bits6:5 and the power-up field from bits 7 and 0, and it clears the second enable while keeping the first. Busy is then high for exactly BUSY_CYCLES cycles, starting the cycle after the stop.
- R6: With both enables set, a byte with bits4:3 = 00, bit2 = 1 and bit1 = 1 is acknowledged but leaves the persistent fields unchanged, keeps both enables set, and does not raise busy.
- R7: Every other control byte is refused and has no effect at the following stop.
- R8: A write byte with wr_first low is refused and discards the pending first byte, so the following stop changes nothing.
- R9: While wp is high, every write to either register is refused and has no effect.
- R10: While busy is high, every write is refused and has no effect. Reads still return current contents.
- R11: A fault-byte write needs no enable. At the stop it stores data & D8h (bit7 = supply-low flag, bit6 = second-monitor flag, bit4 = watchdog flag, bit3 = manual-reset flag), and every other bit reads 0.
- R12: A pulse on ev_vcc_low, ev_v2_low, ev_wdt or ev_mrst clears fault bit 7, 6, 4 or 3, respectively, from the next cycle on. If the pulse lands in the same cycle as a committing fault write, the event wins.
- R13: ack_vld is high exactly in the cycle after each wr_stb, and ack gives that byte's acceptance.
- R14: A stop with no acknowledged pending byte changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register address for the current write or read byte |
| wr_stb | input | 1 | One write data byte is present |
| wr_first | input | 1 | The write byte is the first data byte of its transaction |
| wr_data | input | 8 | Write data byte |
| stop_stb | input | 1 | Transaction ended by a stop |
| rd_stb | input | 1 | Read request for reg_addr |
| wp | input | 1 | Write protect, high refuses all writes |
| ev_vcc_low | input | 1 | Supply-low event pulse |
| ev_v2_low | input | 1 | Second-monitor low event pulse |
| ev_wdt | input | 1 | Watchdog timeout event pulse |
| ev_mrst | input | 1 | Manual reset event pulse |
| rd_data | output | 8 | Read data |
| ack_vld | output | 1 | Acknowledge valid for the previous write byte |
| ack | output | 1 | 1 = byte accepted, 0 = refused |
| busy | output | 1 | Nonvolatile store in progress |
| wd_bits | output | 2 | Watchdog interval selection |
| pup_bits | output | 2 | Power-up delay selection |

## Verification
The bench builds the block with BUSY_CYCLES = 8, so the busy window of each persistent store finishes in a few cycles. This lets it sweep all 256 control byte values from each of the three enable states, with a read-back after every step. It also sweeps all 256 fault-byte values and covers every event pulse, including an event that collides with a commit. The address parameters keep their default values, so a read of an unused address is covered as well.

// File: rtl/supv_regfile_pkg.sv
package supv_regfile_pkg;

   localparam int BYTE_W = 8;

   // control byte bit positions
   localparam int B_PUP_HI = 7;
   localparam int B_WD_HI  = 6;
   localparam int B_WD_LO  = 5;
   localparam int B_EN2    = 2;
   localparam int B_EN1    = 1;
   localparam int B_PUP_LO = 0;

   // fault byte bit positions
   localparam int F_VCC = 7;
   localparam int F_V2  = 6;
   localparam int F_WDT = 4;
   localparam int F_MR  = 3;

   localparam logic [BYTE_W-1:0] CMD_EN1   = 8'h02;
   localparam logic [BYTE_W-1:0] CMD_BOTH  = 8'h06;
   localparam logic [BYTE_W-1:0] CMD_DROP  = 8'h00;
   localparam logic [BYTE_W-1:0] FAULT_USE = 8'hD8;

   typedef enum logic [1:0] {SEL_NONE, SEL_CTRL, SEL_FAULT} reg_sel_e;

   typedef enum logic [2:0] {
      OP_NONE, OP_SET_EN1, OP_SET_BOTH, OP_DROP, OP_NV_WRITE, OP_NV_HOLD
   } ctrl_op_e;

   typedef struct packed {
      logic vcc_low;
      logic v2_low;
      logic wdt;
      logic mrst;
   } fault_ev_t;

endpackage

// File: rtl/supv_wr_front.sv
module supv_wr_front
   import supv_regfile_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic              wr_first,
   input  logic [BYTE_W-1:0] wr_data,
   input  reg_sel_e          wr_sel,
   input  logic              stop_stb,
   input  logic              wp,
   input  logic              busy,
   input  logic              ctrl_ok,
   output logic              ack_vld,
   output logic              ack,
   output logic              ctrl_commit,
   output logic              fault_commit,
   output logic [BYTE_W-1:0] commit_data
);

   logic     take;
   logic     pend_vld;
   reg_sel_e pend_sel;

   assign take = wr_first && !wp && !busy &&
                 ((wr_sel == SEL_FAULT) || ((wr_sel == SEL_CTRL) && ctrl_ok));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_vld     <= 1'b0;
         ack         <= 1'b0;
         pend_vld    <= 1'b0;
         pend_sel    <= SEL_NONE;
         commit_data <= '0;
      end else begin
         ack_vld <= wr_stb;
         if (wr_stb) ack <= take;
         if (stop_stb) begin
            pend_vld <= 1'b0;
         end else if (wr_stb) begin
            pend_vld    <= take;
            pend_sel    <= wr_sel;
            commit_data <= wr_data;
         end
      end
   end

   assign ctrl_commit  = stop_stb && pend_vld && (pend_sel == SEL_CTRL);
   assign fault_commit = stop_stb && pend_vld && (pend_sel == SEL_FAULT);

endmodule

// File: rtl/supv_ctrl_reg.sv
module supv_ctrl_reg
   import supv_regfile_pkg::*;
#(
   parameter logic [1:0] WD_INIT  = 2'b11,
   parameter logic [1:0] PUP_INIT = 2'b01
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] chk_data,
   output logic              chk_ok,
   input  logic              commit,
   input  logic [BYTE_W-1:0] commit_data,
   output logic              nv_start,
   output logic [BYTE_W-1:0] ctrl_byte,
   output logic [1:0]        wd_bits,
   output logic [1:0]        pup_bits
);

   logic       en1_q, en2_q;
   logic [1:0] wd_q, pup_q;
   ctrl_op_e   commit_op;

   function automatic ctrl_op_e decode_op(input logic [BYTE_W-1:0] d,
                                          input logic en1, input logic en2);
      if (en1 && en2 && d[4:3] == 2'b00 && d[B_EN1])
         return d[B_EN2] ? OP_NV_HOLD : OP_NV_WRITE;
      else if (d == CMD_EN1)
         return OP_SET_EN1;
      else if (en1 && d == CMD_BOTH)
         return OP_SET_BOTH;
      else if (en1 && d == CMD_DROP)
         return OP_DROP;
      else
         return OP_NONE;
   endfunction

   assign chk_ok    = decode_op(chk_data, en1_q, en2_q) != OP_NONE;
   assign commit_op = decode_op(commit_data, en1_q, en2_q);
   assign nv_start  = commit && (commit_op == OP_NV_WRITE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en1_q <= 1'b0;
         en2_q <= 1'b0;
         wd_q  <= WD_INIT;
         pup_q <= PUP_INIT;
      end else if (commit) begin
         case (commit_op)
            OP_SET_EN1:  en1_q <= 1'b1;
            OP_SET_BOTH: begin
               en1_q <= 1'b1;
               en2_q <= 1'b1;
            end
            OP_DROP: begin
               en1_q <= 1'b0;
               en2_q <= 1'b0;
            end
            OP_NV_WRITE: begin
               wd_q  <= commit_data[B_WD_HI:B_WD_LO];
               pup_q <= {commit_data[B_PUP_HI], commit_data[B_PUP_LO]};
               en2_q <= 1'b0;
            end
            default: ;
         endcase
      end
   end

   assign ctrl_byte = {pup_q[1], wd_q, 2'b00, en2_q, en1_q, pup_q[0]};
   assign wd_bits   = wd_q;
   assign pup_bits  = pup_q;

endmodule

// File: rtl/supv_fault_reg.sv
module supv_fault_reg
   import supv_regfile_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic [3:0]        commit_flags,
   input  fault_ev_t         events,
   output logic [BYTE_W-1:0] fault_byte
);

   logic [3:0] flags_q;
   logic [3:0] flags_nxt;

   assign flags_nxt = commit ? commit_flags : flags_q;

   always_ff @(posedge clk) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= flags_nxt & ~{events.vcc_low, events.v2_low, events.wdt, events.mrst};
   end

   always_comb begin
      fault_byte        = '0;
      fault_byte[F_VCC] = flags_q[3];
      fault_byte[F_V2]  = flags_q[2];
      fault_byte[F_WDT] = flags_q[1];
      fault_byte[F_MR]  = flags_q[0];
   end

endmodule

// File: rtl/supv_nv_timer.sv
module supv_nv_timer #(
   parameter int BUSY_CYCLES = 500000
)(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   localparam int CNT_W = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES + 1);

   generate
      if (BUSY_CYCLES == 0) begin : g_none
         assign busy = 1'b0;
      end else begin : g_cnt
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)           cnt_q <= '0;
            else if (start)       cnt_q <= CNT_W'(BUSY_CYCLES);
            else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
         end
         assign busy = (cnt_q != '0);
      end
   endgenerate

endmodule

// File: rtl/supv_regfile.sv
module supv_regfile
   import supv_regfile_pkg::*;
#(
   parameter int          ADDR_W      = 9,
   parameter logic [8:0]  CTRL_ADDR   = 9'h1FF,
   parameter logic [8:0]  FAULT_ADDR  = 9'h0FF,
   parameter int          BUSY_CYCLES = 500000,
   parameter logic [1:0]  WD_INIT     = 2'b11,
   parameter logic [1:0]  PUP_INIT    = 2'b01
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              wr_stb,
   input  logic              wr_first,
   input  logic [7:0]        wr_data,
   input  logic              stop_stb,
   input  logic              rd_stb,
   input  logic              wp,
   input  logic              ev_vcc_low,
   input  logic              ev_v2_low,
   input  logic              ev_wdt,
   input  logic              ev_mrst,
   output logic [7:0]        rd_data,
   output logic              ack_vld,
   output logic              ack,
   output logic              busy,
   output logic [1:0]        wd_bits,
   output logic [1:0]        pup_bits
);

   generate
      if (ADDR_W < 9) begin : g_bad_width
         $error("supv_regfile: ADDR_W must be at least 9");
      end
      if (CTRL_ADDR == FAULT_ADDR) begin : g_bad_map
         $error("supv_regfile: register addresses must differ");
      end
      if (BUSY_CYCLES < 0) begin : g_bad_busy
         $error("supv_regfile: BUSY_CYCLES must not be negative");
      end
   endgenerate

   reg_sel_e          sel;
   logic              ctrl_ok, ctrl_commit, fault_commit, nv_start;
   logic [BYTE_W-1:0] commit_data, ctrl_byte, fault_byte;
   fault_ev_t         events;

   always_comb begin
      if (reg_addr == ADDR_W'(CTRL_ADDR))       sel = SEL_CTRL;
      else if (reg_addr == ADDR_W'(FAULT_ADDR)) sel = SEL_FAULT;
      else                                      sel = SEL_NONE;
   end

   assign events = '{vcc_low: ev_vcc_low, v2_low: ev_v2_low, wdt: ev_wdt, mrst: ev_mrst};

   supv_wr_front u_front (
      .clk, .rst_n, .wr_stb, .wr_first, .wr_data,
      .wr_sel(sel), .stop_stb, .wp, .busy, .ctrl_ok,
      .ack_vld, .ack, .ctrl_commit, .fault_commit, .commit_data
   );

   supv_ctrl_reg #(.WD_INIT(WD_INIT), .PUP_INIT(PUP_INIT)) u_ctrl (
      .clk, .rst_n, .chk_data(wr_data), .chk_ok(ctrl_ok),
      .commit(ctrl_commit), .commit_data, .nv_start,
      .ctrl_byte, .wd_bits, .pup_bits
   );

   supv_fault_reg u_fault (
      .clk, .rst_n, .commit(fault_commit),
      .commit_flags({commit_data[F_VCC], commit_data[F_V2], commit_data[F_WDT], commit_data[F_MR]}),
      .events, .fault_byte
   );

   supv_nv_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
      .clk, .rst_n, .start(nv_start), .busy
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (rd_stb) begin
         case (sel)
            SEL_CTRL:  rd_data <= ctrl_byte;
            SEL_FAULT: rd_data <= fault_byte;
            default:   rd_data <= '0;
         endcase
      end
   end

endmodule

// File: rtl/supv_regfile_chk.sv
module supv_regfile_chk #(
   parameter int BUSY_CYCLES = 500000
)(
   input logic       clk,
   input logic       rst_n,
   input logic       wr_stb,
   input logic       wr_first,
   input logic       wp,
   input logic       busy,
   input logic       ack_vld,
   input logic       ack,
   input logic [1:0] wd_bits,
   input logic [1:0] pup_bits,
   input logic       ev_vcc_low,
   input logic       ev_v2_low,
   input logic       ev_wdt,
   input logic       ev_mrst,
   input logic [7:0] ctrl_byte,
   input logic [7:0] fault_byte
);

   p_ack_follows_r13: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> ack_vld);
   p_ack_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> !ack_vld);
   p_second_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb && !wr_first |=> !ack);
   p_wp_nack_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb && wp |=> !ack);
   p_busy_nack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb && busy |=> !ack);
   p_en2_needs_en1_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_byte[2] |-> ctrl_byte[1]);
   p_ev_vcc_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ev_vcc_low |=> !fault_byte[7]);
   p_ev_v2_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ev_v2_low |=> !fault_byte[6]);
   p_ev_wdt_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ev_wdt |=> !fault_byte[4]);
   p_ev_mr_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ev_mrst |=> !fault_byte[3]);

   generate
      if (BUSY_CYCLES > 0) begin : g_nv
         p_nv_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable({wd_bits, pup_bits}) |-> $rose(busy));
      end
   endgenerate

endmodule

bind supv_regfile supv_regfile_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_first(wr_first), .wp(wp),
   .busy(busy), .ack_vld(ack_vld), .ack(ack), .wd_bits(wd_bits),
   .pup_bits(pup_bits), .ev_vcc_low(ev_vcc_low), .ev_v2_low(ev_v2_low),
   .ev_wdt(ev_wdt), .ev_mrst(ev_mrst), .ctrl_byte(ctrl_byte),
   .fault_byte(fault_byte)
);

// File: tb/tb_supv_regfile.sv
module tb_supv_regfile;

   localparam int BUSY = 8;
   localparam logic [8:0] A_CTRL  = 9'h1FF;
   localparam logic [8:0] A_FAULT = 9'h0FF;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [8:0] reg_addr = '0;
   logic       wr_stb = 0, wr_first = 0, stop_stb = 0, rd_stb = 0, wp = 0;
   logic [7:0] wr_data = '0;
   logic       ev_vcc_low = 0, ev_v2_low = 0, ev_wdt = 0, ev_mrst = 0;
   logic [7:0] rd_data;
   logic       ack_vld, ack, busy;
   logic [1:0] wd_bits, pup_bits;

   int n_chk = 0;
   int n_bad = 0;

   // bench model of state
   logic       m_en1 = 0, m_en2 = 0;
   logic [1:0] m_wd = 2'b11, m_pup = 2'b01;
   logic [7:0] m_fault = 8'h00;

   always #10 clk = ~clk;

   supv_regfile #(.BUSY_CYCLES(BUSY)) dut (
      .clk, .rst_n, .reg_addr, .wr_stb, .wr_first, .wr_data, .stop_stb,
      .rd_stb, .wp, .ev_vcc_low, .ev_v2_low, .ev_wdt, .ev_mrst,
      .rd_data, .ack_vld, .ack, .busy, .wd_bits, .pup_bits
   );

   task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] m_ctrl();
      return {m_pup[1], m_wd, 2'b00, m_en2, m_en1, m_pup[0]};
   endfunction

   // 0 none, 1 en1, 2 both, 3 drop, 4 nv write, 5 nv hold
   function automatic int m_op(input logic [7:0] d);
      if (m_en1 && m_en2 && d[4:3] == 2'b00 && d[1]) return d[2] ? 5 : 4;
      if (d == 8'h02) return 1;
      if (m_en1 && d == 8'h06) return 2;
      if (m_en1 && d == 8'h00) return 3;
      return 0;
   endfunction

   task automatic wr_byte(input logic [8:0] a, input logic [7:0] d, input logic first,
                          input logic exp_ack, input string tag);
      reg_addr = a; wr_data = d; wr_first = first; wr_stb = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0; wr_first = 1'b0;
      check8({tag, " ack"}, {6'b0, ack_vld, ack}, {6'b0, 1'b1, exp_ack});
   endtask

   task automatic do_stop();
      stop_stb = 1'b1;
      @(negedge clk);
      stop_stb = 1'b0;
      check8("R13 ack_vld low", {7'b0, ack_vld}, 8'h00);
   endtask

   task automatic rd(input logic [8:0] a, input logic [7:0] exp, input string tag);
      reg_addr = a; rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
      check8(tag, rd_data, exp);
   endtask

   task automatic wait_busy(input string tag);
      int n = 0;
      while (busy === 1'b1 && n < 100) begin
         n++;
         @(negedge clk);
      end
      check8(tag, 8'(n), 8'(BUSY));
   endtask

   task automatic ctrl_txn(input logic [7:0] d);
      int    op;
      string tag;
      op = m_op(d);
      case (op)
         0: tag = "R7";
         1: tag = "R3";
         2, 3: tag = "R4";
         4: tag = "R5";
         default: tag = "R6";
      endcase
      wr_byte(A_CTRL, d, 1'b1, op != 0, tag);
      do_stop();
      case (op)
         1: m_en1 = 1;
         2: begin m_en1 = 1; m_en2 = 1; end
         3: begin m_en1 = 0; m_en2 = 0; end
         4: begin m_wd = d[6:5]; m_pup = {d[7], d[0]}; m_en2 = 0; end
         default: ;
      endcase
      if (op == 4) wait_busy("R5 busy length");
      else check8({tag, " no busy"}, {7'b0, busy}, 8'h00);
      rd(A_CTRL, m_ctrl(), {tag, " readback"});
      check8({tag, " field ports"}, {4'b0, wd_bits, pup_bits}, {4'b0, m_wd, m_pup});
   endtask

   task automatic goto_state(input int st);
      if (m_en1) ctrl_txn(8'h00);
      if (st >= 1) ctrl_txn(8'h02);
      if (st == 2) ctrl_txn(8'h06);
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check8("R1 busy", {7'b0, busy}, 8'h00);
      check8("R1 fields", {4'b0, wd_bits, pup_bits}, 8'h0D);
      rd(A_CTRL, 8'h61, "R1 ctrl");
      rd(A_FAULT, 8'h00, "R1 fault");
      rd(9'h000, 8'h00, "R2 unused address");

      // R3..R7 sweep every byte from every enable state (reads between steps: R2)
      for (int st = 0; st < 3; st++) begin
         for (int v = 0; v < 256; v++) begin
            goto_state(st);
            ctrl_txn(8'(v));
         end
      end

      // R8 second byte refused, pending discarded
      goto_state(1);
      wr_byte(A_CTRL, 8'h06, 1'b1, 1'b1, "R8 first");
      wr_byte(A_CTRL, 8'h06, 1'b0, 1'b0, "R8 second");
      do_stop();
      rd(A_CTRL, m_ctrl(), "R8 ctrl unchanged");
      wr_byte(A_FAULT, 8'hFF, 1'b1, 1'b1, "R8 fault first");
      wr_byte(A_FAULT, 8'h00, 1'b0, 1'b0, "R8 fault second");
      do_stop();
      rd(A_FAULT, m_fault, "R8 fault unchanged");

      // R9 write protect
      goto_state(0);
      wp = 1'b1;
      wr_byte(A_CTRL, 8'h02, 1'b1, 1'b0, "R9 ctrl");
      do_stop();
      wr_byte(A_FAULT, 8'hFF, 1'b1, 1'b0, "R9 fault");
      do_stop();
      wp = 1'b0;
      rd(A_CTRL, m_ctrl(), "R9 ctrl unchanged");
      rd(A_FAULT, m_fault, "R9 fault unchanged");

      // R10 busy window
      goto_state(2);
      wr_byte(A_CTRL, 8'h83, 1'b1, 1'b1, "R10 nv write");
      do_stop();
      m_wd = 2'b00; m_pup = 2'b11; m_en2 = 0;
      check8("R10 busy high", {7'b0, busy}, 8'h01);
      wr_byte(A_FAULT, 8'hFF, 1'b1, 1'b0, "R10 fault while busy");
      do_stop();
      wr_byte(A_CTRL, 8'h00, 1'b1, 1'b0, "R10 ctrl while busy");
      do_stop();
      rd(A_CTRL, m_ctrl(), "R10 read while busy");
      rd(A_FAULT, m_fault, "R10 fault unchanged");
      while (busy === 1'b1) @(negedge clk);

      // R14 lone stop
      do_stop();
      rd(A_CTRL, m_ctrl(), "R14 ctrl");
      rd(A_FAULT, m_fault, "R14 fault");

      // R11 fault sweep
      for (int v = 0; v < 256; v++) begin
         wr_byte(A_FAULT, 8'(v), 1'b1, 1'b1, "R11 write");
         do_stop();
         m_fault = 8'(v) & 8'hD8;
         rd(A_FAULT, m_fault, "R11 readback");
      end

      // R12 each event clears its own flag
      for (int e = 0; e < 4; e++) begin
         wr_byte(A_FAULT, 8'hFF, 1'b1, 1'b1, "R12 arm");
         do_stop();
         ev_vcc_low = (e == 0); ev_v2_low = (e == 1); ev_wdt = (e == 2); ev_mrst = (e == 3);
         @(negedge clk);
         ev_vcc_low = 0; ev_v2_low = 0; ev_wdt = 0; ev_mrst = 0;
         case (e)
            0: m_fault = 8'h58;
            1: m_fault = 8'h98;
            2: m_fault = 8'hC8;
            default: m_fault = 8'hD0;
         endcase
         rd(A_FAULT, m_fault, "R12 event clear");
      end

      // R12 event colliding with commit
      wr_byte(A_FAULT, 8'hFF, 1'b1, 1'b1, "R12 collide arm");
      stop_stb = 1'b1; ev_wdt = 1'b1;
      @(negedge clk);
      stop_stb = 1'b0; ev_wdt = 1'b0;
      m_fault = 8'hC8;
      rd(A_FAULT, m_fault, "R12 event beats commit");

      finish_run();
   end

endmodule